// File: doc/BRIEF.md
# Shared Block Data Buffer

This block is the staging store between a system bus and a set of memory channels. It holds a fixed pool of entries, each one cache block wide. The same pool stages write data on its way to memory and read data on its way back to the bus. The bus side moves a whole block per access. Each memory channel has its own read and write port, and each of those moves one doubleword per access. The entry index is the one the request queue assigned when it allocated the request, so no separate address translation is needed.

Allocation marks an entry empty. Every doubleword written into the entry sets a per-doubleword fill bit, from either side. A per-entry "complete" flag goes high once all doublewords of a block are present. The scheduler uses this flag to tell when a write is ready for memory or a read block is ready for the bus. Freeing entries and error correction belong to neighbouring logic.

Top module: `blkbuf_top`

## Requirements
- R1: A bus block write stores all 256 bits of the addressed entry. A bus read issued in cycle N returns that entry's 256 bits on `brd_data`, with `brd_vld` high, in cycle N+1. `brd_vld` is low in any cycle after a cycle without a bus read.
- R2: A channel read with doubleword index i (0 to 3) returns entry bits [64*i+63:64*i] on that channel's 64-bit slice of `ch_rd_data`, with its `ch_rd_vld` bit high, one cycle after the request. Each channel's read port works independently of the others.
- R3: A channel write with doubleword index i changes only bits [64*i+63:64*i] of the addressed entry. The other three doublewords keep their contents.
- R4: A bus write sets all four fill bits of its entry. A successful channel write sets only the bit of its doubleword. `ent_full[e]` is high, one cycle after the write, exactly when all four fill bits of entry e are set.
- R5: Allocation clears all fill bits of the entry and no other entry. If a write hits the same entry in the same cycle, the write's fill bits are set on top of the cleared state.
- R6: When a bus write and a channel write target the same entry in the same cycle, the bus data is kept in every doubleword. That channel's `ch_clash` bit pulses high in the following cycle.
- R7: When two channels write the same doubleword of the same entry in one cycle, the lower-numbered channel's data is kept and the higher channel's `ch_clash` bit pulses. Channel writes to different doublewords or different entries all take effect, and none of them is flagged.
- R8: A read and a write to the same location in the same cycle return the contents from before the write.
- R9: Synchronous reset clears every fill bit, `ent_full`, `brd_vld`, `ch_rd_vld` and `ch_clash`. Stored data is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Allocate (empty) an entry |
| alloc_idx | input | 4 | Entry to allocate |
| bus_wr_en | input | 1 | Bus-side block write |
| bus_wr_idx | input | 4 | Bus write entry |
| bus_wr_data | input | 256 | Bus write block |
| brd_en | input | 1 | Bus-side block read |
| brd_idx | input | 4 | Bus read entry |
| brd_data | output | 256 | Bus read block |
| brd_vld | output | 1 | Bus read data valid |
| ch_wr_en | input | 2 | Per-channel doubleword write |
| ch_wr_idx | input | 8 | Per-channel write entry, 4 bits each |
| ch_wr_dw | input | 4 | Per-channel write doubleword index, 2 bits each |
| ch_wr_data | input | 128 | Per-channel write doubleword, 64 bits each |
| ch_rd_en | input | 2 | Per-channel doubleword read |
| ch_rd_idx | input | 8 | Per-channel read entry, 4 bits each |
| ch_rd_dw | input | 4 | Per-channel read doubleword index, 2 bits each |
| ch_rd_data | output | 128 | Per-channel read doubleword, 64 bits each |
| ch_rd_vld | output | 2 | Per-channel read data valid |
| ch_clash | output | 2 | Per-channel pulse: the write one cycle earlier was overridden |
| ent_full | output | 16 | Per-entry all-doublewords-present flag |

## Verification
The bench builds the block with its default parameters: 16 entries, 256-bit blocks, 64-bit doublewords and two channels. Two channels are the smallest count that makes channel-against-channel conflicts possible. With them, the bench can show both the lower-index win on a shared doubleword and the conflict-free case of concurrent writes to different doublewords of one entry. Sixteen entries let the bench fill, re-allocate and partly refill several entries. It can then check that allocation and completion affect one entry and leave its neighbours alone.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;
  localparam int DEF_ENTRIES = 16;
  localparam int DEF_BLOCK_W = 256;
  localparam int DEF_DW_W    = 64;
  localparam int DEF_NUM_CH  = 2;

  function automatic int lanes_of(input int block_w, input int dw_w);
    return block_w / dw_w;
  endfunction
endpackage

// File: rtl/blkbuf_lane.sv
// One doubleword lane of the buffer: every entry's slice at this lane position.
// One bus write port, one write port per channel (already conflict-masked),
// one registered bus read port and one registered read port per channel.
module blkbuf_lane #(
  parameter int ENTRIES = 16,
  parameter int DW_W    = 64,
  parameter int NCH     = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  bus_we,
  input  logic [IDX_W-1:0]      bus_widx,
  input  logic [DW_W-1:0]       bus_wdata,
  input  logic [NCH-1:0]        ch_we,
  input  logic [NCH*IDX_W-1:0]  ch_widx,
  input  logic [NCH*DW_W-1:0]   ch_wdata,
  input  logic                  bus_re,
  input  logic [IDX_W-1:0]      bus_ridx,
  output logic [DW_W-1:0]       bus_rdata,
  input  logic [NCH-1:0]        ch_re,
  input  logic [NCH*IDX_W-1:0]  ch_ridx,
  output logic [NCH*DW_W-1:0]   ch_rdata
);
  logic [DW_W-1:0] mem [ENTRIES];

  // Writes: the arbiter guarantees at most one enabled writer per entry.
  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (ch_we[c]) mem[ch_widx[c*IDX_W +: IDX_W]] <= ch_wdata[c*DW_W +: DW_W];
    end
    if (bus_we) mem[bus_widx] <= bus_wdata;
  end

  // Reads sample the array before this edge's writes land (R8).
  always_ff @(posedge clk) begin
    if (bus_re) bus_rdata <= mem[bus_ridx];
    for (int c = 0; c < NCH; c++) begin
      if (ch_re[c]) ch_rdata[c*DW_W +: DW_W] <= mem[ch_ridx[c*IDX_W +: IDX_W]];
    end
  end
endmodule

// File: rtl/blkbuf_warb.sv
// Write arbitration: bus beats any channel on the same entry (R6);
// a lower channel beats a higher one on the same entry and doubleword (R7).
module blkbuf_warb #(
  parameter int NCH   = 2,
  parameter int IDX_W = 4,
  parameter int DWI_W = 2
) (
  input  logic                  bus_we,
  input  logic [IDX_W-1:0]      bus_idx,
  input  logic [NCH-1:0]        ch_we,
  input  logic [NCH*IDX_W-1:0]  ch_idx,
  input  logic [NCH*DWI_W-1:0]  ch_dw,
  output logic [NCH-1:0]        ch_ok,
  output logic [NCH-1:0]        ch_lost
);
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic beaten;
      beaten = bus_we && (bus_idx == ch_idx[c*IDX_W +: IDX_W]);
      for (int j = 0; j < c; j++) begin
        if (ch_we[j] &&
            ch_idx[j*IDX_W +: IDX_W] == ch_idx[c*IDX_W +: IDX_W] &&
            ch_dw[j*DWI_W +: DWI_W]  == ch_dw[c*DWI_W +: DWI_W])
          beaten = 1'b1;
      end
      ch_lost[c] = ch_we[c] && beaten;
      ch_ok[c]   = ch_we[c] && !beaten;
    end
  end
endmodule

// File: rtl/blkbuf_fill.sv
// Per-doubleword fill tracking and the registered per-entry complete flag.
module blkbuf_fill #(
  parameter int ENTRIES = 16,
  parameter int NDW     = 4,
  parameter int NCH     = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int DWI_W  = $clog2(NDW)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc_en,
  input  logic [IDX_W-1:0]      alloc_idx,
  input  logic                  bus_we,
  input  logic [IDX_W-1:0]      bus_idx,
  input  logic [NCH-1:0]        ch_ok,
  input  logic [NCH*IDX_W-1:0]  ch_idx,
  input  logic [NCH*DWI_W-1:0]  ch_dw,
  output logic [ENTRIES-1:0]    full
);
  logic [NDW-1:0] vb     [ENTRIES];
  logic [NDW-1:0] vb_nxt [ENTRIES];

  // Allocation clears first, then writes set their bits (R5, R4).
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      vb_nxt[e] = vb[e];
      if (alloc_en && alloc_idx == IDX_W'(e)) vb_nxt[e] = '0;
      if (bus_we && bus_idx == IDX_W'(e))     vb_nxt[e] = '1;
      for (int c = 0; c < NCH; c++) begin
        if (ch_ok[c] && ch_idx[c*IDX_W +: IDX_W] == IDX_W'(e))
          vb_nxt[e][ch_dw[c*DWI_W +: DWI_W]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (rst) begin
        vb[e]   <= '0;
        full[e] <= 1'b0;
      end else begin
        vb[e]   <= vb_nxt[e];
        full[e] <= &vb_nxt[e];
      end
    end
  end
endmodule

// File: rtl/blkbuf_top.sv
module blkbuf_top
  import blkbuf_pkg::*;
#(
  parameter int NUM_ENTRIES = DEF_ENTRIES,
  parameter int BLOCK_W     = DEF_BLOCK_W,
  parameter int DW_W        = DEF_DW_W,
  parameter int NUM_CH      = DEF_NUM_CH,
  localparam int NDW        = BLOCK_W / DW_W,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int DWI_W      = $clog2(NDW)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_en,
  input  logic [IDX_W-1:0]         alloc_idx,
  input  logic                     bus_wr_en,
  input  logic [IDX_W-1:0]         bus_wr_idx,
  input  logic [BLOCK_W-1:0]       bus_wr_data,
  input  logic                     brd_en,
  input  logic [IDX_W-1:0]         brd_idx,
  output logic [BLOCK_W-1:0]       brd_data,
  output logic                     brd_vld,
  input  logic [NUM_CH-1:0]        ch_wr_en,
  input  logic [NUM_CH*IDX_W-1:0]  ch_wr_idx,
  input  logic [NUM_CH*DWI_W-1:0]  ch_wr_dw,
  input  logic [NUM_CH*DW_W-1:0]   ch_wr_data,
  input  logic [NUM_CH-1:0]        ch_rd_en,
  input  logic [NUM_CH*IDX_W-1:0]  ch_rd_idx,
  input  logic [NUM_CH*DWI_W-1:0]  ch_rd_dw,
  output logic [NUM_CH*DW_W-1:0]   ch_rd_data,
  output logic [NUM_CH-1:0]        ch_rd_vld,
  output logic [NUM_CH-1:0]        ch_clash,
  output logic [NUM_ENTRIES-1:0]   ent_full
);
  logic [NUM_CH-1:0]        ch_ok;
  logic [NUM_CH-1:0]        ch_lost;
  logic [NUM_CH*DWI_W-1:0]  rd_dw_q;
  logic [DW_W-1:0]          lane_bus_q [NDW];
  logic [NUM_CH*DW_W-1:0]   lane_ch_q  [NDW];

  blkbuf_warb #(.NCH(NUM_CH), .IDX_W(IDX_W), .DWI_W(DWI_W)) u_warb (
    .bus_we  (bus_wr_en),
    .bus_idx (bus_wr_idx),
    .ch_we   (ch_wr_en),
    .ch_idx  (ch_wr_idx),
    .ch_dw   (ch_wr_dw),
    .ch_ok   (ch_ok),
    .ch_lost (ch_lost)
  );

  blkbuf_fill #(.ENTRIES(NUM_ENTRIES), .NDW(NDW), .NCH(NUM_CH)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (alloc_en),
    .alloc_idx (alloc_idx),
    .bus_we    (bus_wr_en),
    .bus_idx   (bus_wr_idx),
    .ch_ok     (ch_ok),
    .ch_idx    (ch_wr_idx),
    .ch_dw     (ch_wr_dw),
    .full      (ent_full)
  );

  // One storage lane per doubleword position (R1, R3).
  for (genvar l = 0; l < NDW; l++) begin : g_lane
    logic [NUM_CH-1:0] cwe;
    logic [NUM_CH-1:0] cre;

    always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
        cwe[c] = ch_ok[c]    && (ch_wr_dw[c*DWI_W +: DWI_W] == DWI_W'(l));
        cre[c] = ch_rd_en[c] && (ch_rd_dw[c*DWI_W +: DWI_W] == DWI_W'(l));
      end
    end

    blkbuf_lane #(.ENTRIES(NUM_ENTRIES), .DW_W(DW_W), .NCH(NUM_CH)) u_lane (
      .clk       (clk),
      .bus_we    (bus_wr_en),
      .bus_widx  (bus_wr_idx),
      .bus_wdata (bus_wr_data[l*DW_W +: DW_W]),
      .ch_we     (cwe),
      .ch_widx   (ch_wr_idx),
      .ch_wdata  (ch_wr_data),
      .bus_re    (brd_en),
      .bus_ridx  (brd_idx),
      .bus_rdata (lane_bus_q[l]),
      .ch_re     (cre),
      .ch_ridx   (ch_rd_idx),
      .ch_rdata  (lane_ch_q[l])
    );

    assign brd_data[l*DW_W +: DW_W] = lane_bus_q[l];
  end

  // Channel read return: pick the lane remembered from the request (R2).
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ch_rd_data[c*DW_W +: DW_W] = lane_ch_q[rd_dw_q[c*DWI_W +: DWI_W]][c*DW_W +: DW_W];
    end
  end

  always_ff @(posedge clk) begin
    rd_dw_q <= ch_rd_dw;
    if (rst) begin
      brd_vld   <= 1'b0;
      ch_rd_vld <= '0;
      ch_clash  <= '0;
    end else begin
      brd_vld   <= brd_en;
      ch_rd_vld <= ch_rd_en;
      ch_clash  <= ch_lost;
    end
  end
endmodule

// File: rtl/blkbuf_chk.sv
module blkbuf_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int BLOCK_W     = 256,
  parameter int DW_W        = 64,
  parameter int NUM_CH      = 2,
  localparam int NDW        = BLOCK_W / DW_W,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int DWI_W      = $clog2(NDW)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     alloc_en,
  input logic [IDX_W-1:0]         alloc_idx,
  input logic                     bus_wr_en,
  input logic [IDX_W-1:0]         bus_wr_idx,
  input logic [BLOCK_W-1:0]       bus_wr_data,
  input logic                     brd_en,
  input logic [IDX_W-1:0]         brd_idx,
  input logic [BLOCK_W-1:0]       brd_data,
  input logic                     brd_vld,
  input logic [NUM_CH-1:0]        ch_wr_en,
  input logic [NUM_CH*IDX_W-1:0]  ch_wr_idx,
  input logic [NUM_CH*DWI_W-1:0]  ch_wr_dw,
  input logic [NUM_CH*DW_W-1:0]   ch_wr_data,
  input logic [NUM_CH-1:0]        ch_rd_en,
  input logic [NUM_CH*IDX_W-1:0]  ch_rd_idx,
  input logic [NUM_CH*DWI_W-1:0]  ch_rd_dw,
  input logic [NUM_CH*DW_W-1:0]   ch_rd_data,
  input logic [NUM_CH-1:0]        ch_rd_vld,
  input logic [NUM_CH-1:0]        ch_clash,
  input logic [NUM_ENTRIES-1:0]   ent_full
);
  logic ch_hits_alloc;
  always_comb begin
    ch_hits_alloc = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (ch_wr_en[c] && ch_wr_idx[c*IDX_W +: IDX_W] == alloc_idx) ch_hits_alloc = 1'b1;
  end

  p_bus_rd_lat_r1: assert property (@(posedge clk) disable iff (rst)
    brd_en |=> brd_vld);
  p_bus_rd_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !brd_en |=> !brd_vld);
  p_full_after_bus_r4: assert property (@(posedge clk) disable iff (rst)
    bus_wr_en |=> ent_full[$past(bus_wr_idx)]);
  p_alloc_empties_r5: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && !(bus_wr_en && bus_wr_idx == alloc_idx) && !ch_hits_alloc)
      |=> !ent_full[$past(alloc_idx)]);
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (ent_full == '0 && !brd_vld && ch_rd_vld == '0 && ch_clash == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_ch_rd_lat_r2: assert property (@(posedge clk) disable iff (rst)
      ch_rd_en[c] |=> ch_rd_vld[c]);
    p_bus_beats_ch_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr_en && ch_wr_en[c] && ch_wr_idx[c*IDX_W +: IDX_W] == bus_wr_idx)
        |=> ch_clash[c]);
    p_clash_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
      ch_clash[c] |-> $past(ch_wr_en[c]));
  end
endmodule

bind blkbuf_top blkbuf_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .BLOCK_W(BLOCK_W), .DW_W(DW_W), .NUM_CH(NUM_CH)
) u_chk (.*);

// File: tb/blkbuf_top_tb.sv
module blkbuf_top_tb;
  localparam int NE = 16, BW = 256, DW = 64, NCH = 2, IW = 4, DIW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst;
  logic              alloc_en;
  logic [IW-1:0]     alloc_idx;
  logic              bus_wr_en;
  logic [IW-1:0]     bus_wr_idx;
  logic [BW-1:0]     bus_wr_data;
  logic              brd_en;
  logic [IW-1:0]     brd_idx;
  logic [BW-1:0]     brd_data;
  logic              brd_vld;
  logic [NCH-1:0]    ch_wr_en;
  logic [NCH*IW-1:0] ch_wr_idx;
  logic [NCH*DIW-1:0] ch_wr_dw;
  logic [NCH*DW-1:0] ch_wr_data;
  logic [NCH-1:0]    ch_rd_en;
  logic [NCH*IW-1:0] ch_rd_idx;
  logic [NCH*DIW-1:0] ch_rd_dw;
  logic [NCH*DW-1:0] ch_rd_data;
  logic [NCH-1:0]    ch_rd_vld;
  logic [NCH-1:0]    ch_clash;
  logic [NE-1:0]     ent_full;

  blkbuf_top u_dut (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [BW-1:0] mdl  [NE];
  logic [3:0]    fill [NE];
  logic [BW-1:0] qb [$];
  logic [DW-1:0] qc0 [$];
  logic [DW-1:0] qc1 [$];

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] mkblk(input int s);
    logic [BW-1:0] r;
    for (int k = 0; k < 8; k++)
      r[32*k +: 32] = (32'(s) * 32'h01000193) ^ (32'(k) * 32'h9E3779B9) ^ 32'hA5A50000;
    return r;
  endfunction

  function automatic logic [DW-1:0] mkdw(input int s);
    return {32'(s) * 32'h2545F491, 32'hC0DE0000 ^ 32'(s)};
  endfunction

  task automatic idle_inputs();
    alloc_en = 0; alloc_idx = '0; bus_wr_en = 0; bus_wr_idx = '0; bus_wr_data = '0;
    brd_en = 0; brd_idx = '0; ch_wr_en = '0; ch_wr_idx = '0; ch_wr_dw = '0;
    ch_wr_data = '0; ch_rd_en = '0; ch_rd_idx = '0; ch_rd_dw = '0;
  endtask

  task automatic set_chw(input int c, input int e, input int d, input logic [DW-1:0] v);
    ch_wr_en[c] = 1'b1;
    ch_wr_idx[c*IW +: IW] = IW'(e);
    ch_wr_dw[c*DIW +: DIW] = DIW'(d);
    ch_wr_data[c*DW +: DW] = v;
  endtask

  task automatic set_chr(input int c, input int e, input int d);
    ch_rd_en[c] = 1'b1;
    ch_rd_idx[c*IW +: IW] = IW'(e);
    ch_rd_dw[c*DIW +: DIW] = DIW'(d);
  endtask

  // Driver: computes expectations for the inputs now applied, advances one cycle,
  // checks fill/clash outputs and returns inputs to idle.
  task automatic cyc();
    logic [NCH-1:0] lost;
    logic [NE-1:0]  exp_full;
    // reads see pre-write contents (R8)
    if (brd_en) qb.push_back(mdl[brd_idx]);
    for (int c = 0; c < NCH; c++) begin
      if (ch_rd_en[c]) begin
        logic [DW-1:0] v;
        v = mdl[ch_rd_idx[c*IW +: IW]][int'(ch_rd_dw[c*DIW +: DIW])*DW +: DW];
        if (c == 0) qc0.push_back(v); else qc1.push_back(v);
      end
    end
    for (int c = 0; c < NCH; c++) begin
      lost[c] = ch_wr_en[c] && bus_wr_en && (bus_wr_idx == ch_wr_idx[c*IW +: IW]);
      for (int j = 0; j < c; j++)
        if (ch_wr_en[c] && ch_wr_en[j] && ch_wr_idx[j*IW +: IW] == ch_wr_idx[c*IW +: IW] &&
            ch_wr_dw[j*DIW +: DIW] == ch_wr_dw[c*DIW +: DIW]) lost[c] = 1'b1;
    end
    if (alloc_en) fill[alloc_idx] = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_wr_en[c] && !lost[c]) begin
        mdl[ch_wr_idx[c*IW +: IW]][int'(ch_wr_dw[c*DIW +: DIW])*DW +: DW] = ch_wr_data[c*DW +: DW];
        fill[ch_wr_idx[c*IW +: IW]][ch_wr_dw[c*DIW +: DIW]] = 1'b1;
      end
    end
    if (bus_wr_en) begin
      mdl[bus_wr_idx] = bus_wr_data;
      fill[bus_wr_idx] = '1;
    end
    for (int e = 0; e < NE; e++) exp_full[e] = &fill[e];
    @(negedge clk);
    chk("R4 fill status", BW'(ent_full), BW'(exp_full));
    chk("R6/R7 clash flags", BW'(ch_clash), BW'(lost));
    idle_inputs();
  endtask

  // Monitor: scoreboard compare of returned read data (R1, R2, R3, R8).
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (brd_vld) begin
          if (qb.size() == 0) chk("R1 unexpected bus data", 1, 0);
          else chk("R1 bus read block", brd_data, qb.pop_front());
        end
        if (ch_rd_vld[0]) begin
          if (qc0.size() == 0) chk("R2 unexpected ch0 data", 1, 0);
          else chk("R2 ch0 read doubleword", BW'(ch_rd_data[0 +: DW]), BW'(qc0.pop_front()));
        end
        if (ch_rd_vld[1]) begin
          if (qc1.size() == 0) chk("R2 unexpected ch1 data", 1, 0);
          else chk("R2 ch1 read doubleword", BW'(ch_rd_data[DW +: DW]), BW'(qc1.pop_front()));
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NE; e++) fill[e] = '0;
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk("R9 ent_full after reset", BW'(ent_full), 0);
    chk("R9 valids after reset", BW'({brd_vld, ch_rd_vld}), 0);
    chk("R9 clash after reset", BW'(ch_clash), 0);

    for (int e = 0; e < NE; e++) begin alloc_en = 1; alloc_idx = IW'(e); cyc(); end

    // R1 whole-block write and read
    bus_wr_en = 1; bus_wr_idx = 3;  bus_wr_data = mkblk(1); cyc();
    bus_wr_en = 1; bus_wr_idx = 10; bus_wr_data = mkblk(2); brd_en = 1; brd_idx = 3; cyc();
    brd_en = 1; brd_idx = 10; cyc();

    // R4 doubleword fill of entry 5
    for (int d = 0; d < 4; d++) begin
      set_chw(0, 5, d, mkdw(10 + d)); cyc();
      if (d == 2) chk("R4 entry 5 incomplete", BW'(ent_full[5]), 0);
    end
    chk("R4 entry 5 complete", BW'(ent_full[5]), 1);

    // R2 doubleword reads on both channels concurrently
    for (int d = 0; d < 4; d++) begin
      set_chr(1, 5, d); set_chr(0, 3, 3 - d); cyc();
    end

    // R3 partial update of entry 3
    set_chw(1, 3, 2, 64'hDEAD_BEEF_0123_4567); cyc();
    brd_en = 1; brd_idx = 3; cyc();

    // R6 bus write and channel write on the same entry
    bus_wr_en = 1; bus_wr_idx = 7; bus_wr_data = mkblk(3);
    set_chw(0, 7, 1, mkdw(20)); set_chw(1, 9, 1, mkdw(21)); cyc();
    chk("R6 ch0 flagged only", BW'(ch_clash), 2'b01);
    brd_en = 1; brd_idx = 7; cyc();

    // R7 two channels, same entry and doubleword, then different doublewords
    set_chw(0, 8, 0, mkdw(30)); set_chw(1, 8, 0, mkdw(31)); cyc();
    chk("R7 higher channel flagged", BW'(ch_clash), 2'b10);
    set_chw(0, 8, 1, mkdw(32)); set_chw(1, 8, 2, mkdw(33)); cyc();
    chk("R7 no flag on distinct dwords", BW'(ch_clash), 0);
    set_chr(0, 8, 0); set_chr(1, 8, 2); cyc();
    set_chr(0, 8, 1); set_chr(1, 9, 1); cyc();

    // R8 read and write to the same location in one cycle
    brd_en = 1; brd_idx = 3; bus_wr_en = 1; bus_wr_idx = 3; bus_wr_data = mkblk(4);
    set_chr(0, 5, 1); set_chw(0, 5, 1, mkdw(40)); cyc();
    brd_en = 1; brd_idx = 3; set_chr(0, 5, 1); cyc();

    // R5 allocation empties one entry only; same-cycle write survives
    alloc_en = 1; alloc_idx = 3; cyc();
    chk("R5 entry 3 emptied", BW'(ent_full[3]), 0);
    chk("R5 entry 5 untouched", BW'(ent_full[5]), 1);
    alloc_en = 1; alloc_idx = 10; bus_wr_en = 1; bus_wr_idx = 10; bus_wr_data = mkblk(5); cyc();
    chk("R5 alloc with bus write", BW'(ent_full[10]), 1);
    alloc_en = 1; alloc_idx = 5; set_chw(1, 5, 3, mkdw(50)); cyc();
    chk("R5 alloc with channel write", BW'(ent_full[5]), 0);
    for (int d = 0; d < 3; d++) begin set_chw(0, 5, d, mkdw(60 + d)); cyc(); end
    chk("R5 refilled entry complete", BW'(ent_full[5]), 1);
    brd_en = 1; brd_idx = 5; cyc();
    brd_en = 1; brd_idx = 10; cyc();

    repeat (3) cyc();
    chk("R1 bus queue drained", BW'(qb.size()), 0);
    chk("R2 channel queues drained", BW'(qc0.size() + qc1.size()), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule